// File: doc/BRIEF.md
# Selectable-Latency Read Output Stage for a Synchronous SRAM

This block is the read side of a synchronous SRAM. It samples the chip enable, the write enable, the address and the write data on the rising clock edge. It holds a small behavioural storage array and drives the read word onto a three-state data bus. A static mode input chooses the read latency:

- **Flow-through:** the word leaves the array and goes straight to the bus.
- **Pipelined:** the word passes through a rising-edge output register first.

Every sampled cycle is one of three commands: deselect, read or write. All three travel down the same stage chain, so a deselect reaches the bus with exactly the delay of a read. In pipelined mode, this means the bus stays driven for one whole cycle after the deselect edge. It turns off only after the following edge.

An active-low output enable gates the bus drivers combinationally. It does not wait for any clock edge.

Top module: `sram_rd_out_stage`

## Requirements
- R1: With `pipe_mode` = 0 (flow-through), a read sampled at edge k drives `mem[addr]` on `dq` with `bus_en` = 1 from just after edge k until edge k+1. Reads on consecutive edges give consecutive words one cycle apart, which is 2-1-1-1 timing when counting the command clock as clock 1.
- R2: With `pipe_mode` = 1 or left floating (pipelined), a read sampled at edge k drives its word from just after edge k+1 until edge k+2. Back-to-back reads appear one cycle apart, which is 3-1-1-1 timing.
- R3: A deselect (`ce` = 0 at an edge) follows the same latency as a read. In pipelined mode, the word already on the bus stays driven through the cycle after the deselect edge, and `bus_en` falls just after the next edge. In flow-through mode, `bus_en` falls just after the deselect edge.
- R4: A write (`ce` = 1, `we` = 1) stores `wdata` at `addr` on that edge. The bus is not driven in the output slot that belongs to the write. A read of that address on any later edge returns the new word.
- R5: While `oe_n` = 1, `bus_en` is 0 and `dq` is high-impedance. A change of `oe_n` takes effect immediately, without a clock edge.
- R6: While `rst_n` is low, the stage chain holds a deselect and `bus_en` is 0.
- R7: Changes to `ce`, `we` and `addr` between rising edges have no effect on `dq` or `bus_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_mode | input | 1 | 0 = flow-through, 1 or floating = pipelined (static) |
| ce | input | 1 | Chip enable, sampled on the edge; 0 = deselect |
| we | input | 1 | Write enable, sampled on the edge when `ce` = 1 |
| addr | input | AW | Word address |
| wdata | input | DW | Word stored on a write |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq | output | DW | Three-state read data bus |
| bus_en | output | 1 | High while `dq` is being driven |

## Verification
A stage register holding the wrong command shows up at the ports within the command's own latency: one edge in flow-through mode, two in pipelined mode. Depending on which register is wrong, the bus is:

- driven in a write slot,
- released one cycle early after a deselect, or
- kept alive one cycle late after a deselect.

A wrong address or output-data register shows up as a wrong word in the slot where the scoreboard expects the read. Output-enable faults appear within a fraction of a cycle, because the bench checks the bus between edges right after toggling `oe_n`.

// File: rtl/sram_rd_out_stage.sv
module sram_rd_out_stage #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pipe_mode,
  input  logic          ce,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          oe_n,
  output logic [DW-1:0] dq,
  output logic          bus_en
);

  typedef enum logic [1:0] {OP_DESEL, OP_READ, OP_WRITE} op_t;

  logic [DW-1:0] mem [DEPTH];
  op_t           s1_op;
  logic [AW-1:0] s1_addr;
  logic          s2_act;
  logic [DW-1:0] s2_q;
  logic [DW-1:0] rd_word;
  logic          pipe_sel;
  logic          out_act;
  logic [DW-1:0] out_q;

  // anything but a solid low (including a floating pin) selects the registered path
  assign pipe_sel = (pipe_mode !== 1'b0);

  always_ff @(posedge clk)
    if (ce && we) mem[addr] <= wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op   <= OP_DESEL;
      s1_addr <= '0;
      s2_act  <= 1'b0;
      s2_q    <= '0;
    end else begin
      s1_op   <= !ce ? OP_DESEL : (we ? OP_WRITE : OP_READ);
      s1_addr <= addr;
      s2_act  <= (s1_op == OP_READ);
      s2_q    <= rd_word;
    end
  end

  assign rd_word = mem[s1_addr];
  assign out_act = pipe_sel ? s2_act : (s1_op == OP_READ);
  assign out_q   = pipe_sel ? s2_q : rd_word;
  assign bus_en  = out_act & ~oe_n;
  assign dq      = bus_en ? out_q : {DW{1'bz}};

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;

  p_flow_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && !pipe_sel && $past(ce && !we)) |-> out_act);

  p_pipe_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && pipe_sel && $past(ce && !we, 2)) |-> out_act);

  p_desel_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && pipe_sel && $past(!ce) && $past(ce && !we, 2)) |-> out_act);

  p_desel_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && ((pipe_sel && $past(!ce, 2)) || (!pipe_sel && $past(!ce)))) |-> !out_act);

  p_wr_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && ((pipe_sel && $past(ce && we, 2)) || (!pipe_sel && $past(ce && we)))) |-> !out_act);

endmodule

// File: tb/sram_rd_out_stage_test.sv
module sram_rd_out_stage_test;
  localparam int DW = 16;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0, pipe_mode = 1'b0, ce = 1'b0, we = 1'b0, oe_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  wire  [DW-1:0] dq;
  wire           bus_en;

  sram_rd_out_stage #(.DW(DW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .ce(ce), .we(we),
    .addr(addr), .wdata(wdata), .oe_n(oe_n), .dq(dq), .bus_en(bus_en));

  always #5 clk = ~clk;

  typedef struct { int cyc; bit drv; logic [DW-1:0] val; string req; } exp_t;
  exp_t sb[$];
  logic [DW-1:0] model [DEPTH];
  int cyc = 0, errors = 0, checks = 0;
  bit done = 0;

  always @(posedge clk) cyc++;

  task automatic check(bit drv, logic [DW-1:0] val, string req);
    checks++;
    if (bus_en !== drv || (drv && dq !== val)) begin
      errors++;
      $display("FAIL %s: bus_en=%0b dq=%h expected bus_en=%0b dq=%h", req, bus_en, dq, drv, val);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (sb.size() > 0 && sb[0].cyc == cyc) begin
      exp_t it = sb.pop_front();
      check(it.drv, it.val, it.req);
    end
  end

  task automatic cmd(bit c, bit w, int a, logic [DW-1:0] d);
    exp_t it;
    @(negedge clk);
    ce = c; we = w; addr = AW'(a); wdata = d;
    it.cyc = cyc + 1 + (pipe_mode ? 1 : 0);
    if (c && w) begin model[a] = d; it.drv = 0; it.val = '0; it.req = "R4"; end
    else if (c) begin it.drv = 1; it.val = model[a]; it.req = pipe_mode ? "R2" : "R1"; end
    else begin it.drv = 0; it.val = '0; it.req = "R3"; end
    sb.push_back(it);
  endtask

  task automatic do_reset(bit mode);
    repeat (4) @(negedge clk);
    rst_n = 0; ce = 0; pipe_mode = mode;
    repeat (2) @(negedge clk);
    #2 check(1'b0, '0, "R6");
    rst_n = 1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset(1'b0);
    for (int i = 0; i < 8; i++) cmd(1, 1, i, DW'(16'hA100 + i * 16'h0111));
    for (int i = 0; i < 8; i++) cmd(1, 0, i, '0);
    cmd(0, 0, 0, '0);
    cmd(1, 0, 2, '0);
    cmd(1, 1, 9, 16'h5A5A);
    cmd(1, 0, 9, '0);
    cmd(1, 0, 5, '0);
    @(posedge clk); #2;
    begin
      logic [AW-1:0] sa = addr; logic sc = ce; logic sw = we;
      addr = ~sa; ce = ~sc; we = ~sw;
      #1 check(1'b1, model[5], "R7");
      addr = sa; ce = sc; we = sw;
    end
    cmd(0, 0, 0, '0);
    cmd(0, 0, 0, '0);

    do_reset(1'b1);
    for (int i = 0; i < 6; i++) cmd(1, 0, i, '0);
    cmd(0, 0, 0, '0);
    cmd(0, 0, 0, '0);
    cmd(1, 1, 4, 16'hC3C3);
    cmd(1, 0, 4, '0);
    cmd(1, 0, 1, '0);
    cmd(1, 1, 12, 16'h0FF0);
    cmd(1, 0, 12, '0);
    cmd(0, 0, 0, '0);
    cmd(1, 0, 3, '0);
    cmd(1, 0, 3, '0);
    @(posedge clk); #2;
    oe_n = 1;
    #1 check(1'b0, '0, "R5");
    oe_n = 0;
    #1 check(1'b1, model[3], "R5");
    cmd(0, 0, 0, '0);
    cmd(0, 0, 0, '0);
    repeat (4) @(negedge clk);
    #3;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule